// File: doc/BRIEF.md
# Quasi-Bidirectional Port Drive Controller

This block is the digital side of one general-purpose quasi-bidirectional I/O port. It holds the port's output latch and, for every pin, produces the gate enables for the pad: a pull-down enable, a short strong pull-up burst, a medium pull-up that holds a high level while the pin reads high, and an always-on weak keeper. The pad transistors themselves are outside the block. Only the logical timing of the enables is modelled, in oscillator clock cycles.

In normal mode the latch decides the pin state. When a latch bit goes from 0 to 1, the pull-down drops and the strong pull-up fires for a fixed number of cycles so that the line rises quickly. After the burst, the medium pull-up holds the level for as long as the pad still senses a high. An external circuit can pull the pin low and use it as an input. In that case the medium pull-up lets go and only the keeper stays on. In address mode the port carries a registered address byte instead of the latch. Address bits at 1 keep their strong pull-up on for the whole access. Reads return either the sensed pin levels or the latch contents, as chosen by a select input.

The latch write is a single-cycle strobe and is never back-pressured, so the block has no ready signal. All other pins are plain level controls.

Top module: `qbp_port_ctrl`

## Requirements
- R1: In normal mode, a pin whose latch bit is 0 has its pull-down enable on and its strong, medium and weak pull-ups off.
- R2: A write that changes a latch bit from 0 to 1 turns the pull-down off and the strong pull-up on for exactly PULSE_CYCLES (default 2) clock cycles. The burst starts in the cycle after the write edge.
- R3: The weak keeper is on exactly when the driven value of the pin (latch bit, or address bit in address mode) is 1. The pull-down is on exactly when that value is 0.
- R4: In normal mode, the medium pull-up is on when the latch bit is 1, no strong burst is running and pin_sense is high. It goes off in the same cycle that pin_sense goes low.
- R5: In the cycle after addr_mode is sampled high, each pin follows the registered addr_byte. A bit at 1 has the strong pull-up on and the pull-down off. A bit at 0 has the pull-down on. The medium pull-up is off.
- R6: Asserting rst sets all latch bits to 1 at once, with no clock edge needed. It also clears address mode and stops every running burst.
- R7: rd_data returns pin_sense when rd_rmw is 0 and the latch contents when rd_rmw is 1.
- R8: A new 0-to-1 change on a bit whose burst is still counting reloads that bit's burst to the full PULSE_CYCLES length.
- R9: In the clock after addr_mode is sampled low, the pins follow the latch again. Leaving address mode starts no strong burst.
- R10: Writing 1 to a latch bit that already holds 1 starts no strong burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Asynchronous reset, active high |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | WIDTH | New latch value |
| addr_mode | input | 1 | Select address drive for the next cycle |
| addr_byte | input | WIDTH | Address value to drive in address mode |
| pin_sense | input | WIDTH | Pad level above the input threshold |
| rd_rmw | input | 1 | Read source select: 1 = latch, 0 = pins |
| rd_data | output | WIDTH | Read data |
| strong_pu | output | WIDTH | Strong pull-up enable per pin |
| medium_pu | output | WIDTH | Medium pull-up enable per pin |
| weak_pu | output | WIDTH | Weak keeper enable per pin |
| pull_dn | output | WIDTH | Pull-down enable per pin |

## Verification
A wrong burst counter shows up as a strong enable that is one cycle too short or too long, or that never reloads. The per-cycle comparison sees this in the first or second cycle after the write. A wrong latch or address register turns the pull-down and keeper enables the wrong way on the very next clock, and the latch error also shows on a latch read. A stale mode register shows up one cycle after addr_mode changes, as strong enables that do not match the address byte.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
  // which value the pad currently drives
  typedef enum logic {
    SRC_LATCH = 1'b0,
    SRC_ADDR  = 1'b1
  } drv_src_e;
endpackage

// File: rtl/qbp_latch.sv
module qbp_latch
  import qbp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             addr_mode,
  input  logic [WIDTH-1:0] addr_byte,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] addr_q,
  output drv_src_e         src_q,
  output logic [WIDTH-1:0] rise_o
);

  // bits about to change from 0 to 1 at the coming edge
  assign rise_o = wr_en ? (wr_data & ~latch_q) : '0;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      latch_q <= '1;
      addr_q  <= '0;
      src_q   <= SRC_LATCH;
    end else begin
      if (wr_en) latch_q <= wr_data;
      addr_q <= addr_byte;
      src_q  <= addr_mode ? SRC_ADDR : SRC_LATCH;
    end
  end

  // R6
  reset_ones_chk: assert property (@(posedge clk) rst |-> (&latch_q && src_q == SRC_LATCH));

  // R9
  mode_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !addr_mode |=> src_q == SRC_LATCH);

endmodule

// File: rtl/qbp_pulse.sv
module qbp_pulse #(
  parameter int WIDTH        = 8,
  parameter int PULSE_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rise_i,
  output logic [WIDTH-1:0] active_o
);

  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or posedge rst) begin
      if (rst)            cnt <= '0;
      else if (rise_i[b]) cnt <= LOAD;
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign active_o[b] = (cnt != '0);

    // R2
    burst_start_chk: assert property (@(posedge clk) disable iff (rst)
      rise_i[b] |=> active_o[b]);

    // R8
    burst_reload_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(active_o[b]) |-> !$past(rise_i[b]));
  end

endmodule

// File: rtl/qbp_drive.sv
module qbp_drive
  import qbp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  drv_src_e         src,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] addr_q,
  input  logic [WIDTH-1:0] burst,
  input  logic [WIDTH-1:0] pin_sense,
  output logic [WIDTH-1:0] strong_pu,
  output logic [WIDTH-1:0] medium_pu,
  output logic [WIDTH-1:0] weak_pu,
  output logic [WIDTH-1:0] pull_dn
);

  logic [WIDTH-1:0] level;

  always_comb begin
    if (src == SRC_ADDR) begin
      level     = addr_q;
      strong_pu = addr_q;
      medium_pu = '0;
    end else begin
      level     = latch_q;
      strong_pu = latch_q & burst;
      medium_pu = latch_q & ~burst & pin_sense;
    end
    weak_pu = level;
    pull_dn = ~level;
  end

endmodule

// File: rtl/qbp_port_ctrl.sv
module qbp_port_ctrl
  import qbp_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int PULSE_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             addr_mode,
  input  logic [WIDTH-1:0] addr_byte,
  input  logic [WIDTH-1:0] pin_sense,
  input  logic             rd_rmw,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] strong_pu,
  output logic [WIDTH-1:0] medium_pu,
  output logic [WIDTH-1:0] weak_pu,
  output logic [WIDTH-1:0] pull_dn
);

  logic [WIDTH-1:0] latch_q, addr_q, rise, burst;
  drv_src_e         src_q;

  qbp_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .addr_mode(addr_mode), .addr_byte(addr_byte),
    .latch_q(latch_q), .addr_q(addr_q), .src_q(src_q), .rise_o(rise)
  );

  qbp_pulse #(.WIDTH(WIDTH), .PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst(rst), .rise_i(rise), .active_o(burst)
  );

  qbp_drive #(.WIDTH(WIDTH)) u_drive (
    .src(src_q), .latch_q(latch_q), .addr_q(addr_q), .burst(burst),
    .pin_sense(pin_sense), .strong_pu(strong_pu), .medium_pu(medium_pu),
    .weak_pu(weak_pu), .pull_dn(pull_dn)
  );

  assign rd_data = rd_rmw ? latch_q : pin_sense;

  for (genvar p = 0; p < WIDTH; p++) begin : g_chk
    // R1
    low_pin_chk: assert property (@(posedge clk) disable iff (rst)
      (src_q == SRC_LATCH && !latch_q[p]) |-> (pull_dn[p] && !strong_pu[p] && !medium_pu[p]));
    // R3
    pd_keeper_excl_chk: assert property (@(posedge clk) disable iff (rst)
      pull_dn[p] != weak_pu[p]);
    // R4
    medium_release_chk: assert property (@(posedge clk) disable iff (rst)
      !pin_sense[p] |-> !medium_pu[p]);
    // R5
    addr_strong_chk: assert property (@(posedge clk) disable iff (rst)
      (src_q == SRC_ADDR && addr_q[p]) |-> (strong_pu[p] && !pull_dn[p]));
    // R10
    no_repeat_burst_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_data[p] && latch_q[p] && !strong_pu[p] && src_q == SRC_LATCH && !addr_mode)
        |=> !strong_pu[p]);
  end

endmodule

// File: tb/qbp_port_ctrl_bench.sv
`timescale 1ns/100ps
module qbp_port_ctrl_bench;
  localparam int W = 8;
  localparam int P = 2;

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic wr_en = 1'b0, addr_mode = 1'b0, rd_rmw = 1'b0;
  logic [W-1:0] wr_data = '0, addr_byte = '0, pin_sense = '1;
  logic [W-1:0] rd_data, strong_pu, medium_pu, weak_pu, pull_dn;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  qbp_port_ctrl #(.WIDTH(W), .PULSE_CYCLES(P)) u_qbp_port_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .addr_mode(addr_mode), .addr_byte(addr_byte), .pin_sense(pin_sense),
    .rd_rmw(rd_rmw), .rd_data(rd_data), .strong_pu(strong_pu),
    .medium_pu(medium_pu), .weak_pu(weak_pu), .pull_dn(pull_dn)
  );

  // behavioural reference
  logic [W-1:0] m_lat, m_addr;
  bit m_sel;
  int m_cnt[W];

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      m_lat = '1; m_addr = '0; m_sel = 0;
      for (int i = 0; i < W; i++) m_cnt[i] = 0;
    end else begin
      for (int i = 0; i < W; i++) begin
        if (wr_en && wr_data[i] && !m_lat[i]) m_cnt[i] = P;
        else if (m_cnt[i] > 0) m_cnt[i] = m_cnt[i] - 1;
      end
      if (wr_en) m_lat = wr_data;
      m_sel = addr_mode;
      m_addr = addr_byte;
    end
  end

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_strong();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = m_sel ? m_addr[i] : (m_lat[i] && m_cnt[i] > 0);
    return v;
  endfunction

  function automatic logic [W-1:0] exp_medium();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = !m_sel && m_lat[i] && m_cnt[i] == 0 && pin_sense[i];
    return v;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      check("R2 strong_pu", strong_pu, exp_strong());
      check("R4 medium_pu", medium_pu, exp_medium());
      check("R3 weak_pu", weak_pu, m_sel ? m_addr : m_lat);
      check("R1 pull_dn", pull_dn, ~(m_sel ? m_addr : m_lat));
      check("R7 rd_data", rd_data, rd_rmw ? m_lat : pin_sense);
    end
  end

  task automatic nc();
    @(negedge clk); #0.5;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    #1 rst = 1'b1;
    nc(); nc();
    rst = 1'b0; rd_rmw = 1'b1;
    #0.2;
    // R6 reset state
    check("R6 latch after reset", rd_data, 8'hFF);
    check("R6 no burst after reset", strong_pu, 8'h00);
    check("R6 pull_dn after reset", pull_dn, 8'h00);

    // R10 rewrite ones
    wr_en = 1; wr_data = 8'hFF; nc();
    wr_en = 0; check("R10 no burst on 1->1", strong_pu, 8'h00);

    // R1 / R2 clear then set low nibble
    wr_en = 1; wr_data = 8'h00; nc();
    check("R1 pull_dn all low", pull_dn, 8'hFF);
    wr_data = 8'h0F; nc();
    wr_en = 0; check("R2 burst cycle 1", strong_pu, 8'h0F);
    nc(); check("R2 burst cycle 2", strong_pu, 8'h0F);
    nc(); check("R2 burst ended", strong_pu, 8'h00);
    check("R4 medium after burst", medium_pu, 8'h0F);
    pin_sense = 8'h05; #0.2;
    check("R4 medium released", medium_pu, 8'h05);
    pin_sense = 8'hFF;

    // R8 restart
    wr_en = 1; wr_data = 8'h00; nc();
    wr_data = 8'hFF; nc();
    wr_data = 8'h00; nc();
    wr_data = 8'hFF; nc();
    wr_en = 0; nc();
    check("R8 reloaded burst", strong_pu, 8'hFF);
    nc(); check("R8 burst then ends", strong_pu, 8'h00);

    // R5 address mode
    addr_mode = 1; addr_byte = 8'hA5; nc();
    check("R5 strong follows address", strong_pu, 8'hA5);
    check("R5 pull_dn follows address", pull_dn, 8'h5A);
    check("R5 medium off", medium_pu, 8'h00);

    // R9 leave address mode
    addr_mode = 0; nc();
    check("R9 latch restored", pull_dn, 8'h00);
    check("R9 no burst on exit", strong_pu, 8'h00);

    // R7 read select
    rd_rmw = 0; pin_sense = 8'h3C; #0.2;
    check("R7 pin read", rd_data, 8'h3C);
    rd_rmw = 1; #0.2;
    check("R7 latch read", rd_data, 8'hFF);

    // R6 asynchronous reset mid-cycle
    wr_en = 1; wr_data = 8'h00; nc();
    wr_en = 0; #0.3 rst = 1; #0.2;
    check("R6 async latch ones", rd_data, 8'hFF);
    nc(); rst = 0;

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      nc();
      wr_en = ($urandom_range(3) == 0);
      wr_data = W'($urandom);
      if ($urandom_range(15) == 0) addr_mode = ~addr_mode;
      addr_byte = W'($urandom);
      pin_sense = W'($urandom);
      rd_rmw = $urandom_range(1) == 1;
    end
    nc();
    summary();
  end
endmodule